// File: doc/BRIEF.md
# Byte-Indirect Dual Event Counter Unit

This block counts hardware events on two independent 32-bit counters. A host with only an 8-bit data path reaches it through a small window of five byte ports. One port holds an 8-bit index that picks a 32-bit internal register. Four data ports, at offsets 0 to 3, carry that register one byte at a time, with the most significant byte at offset 0. The internal registers are:

- an identification word,
- a control word that selects the event source for each counter and can zero either counter,
- counter 0,
- a shadow copy of counter 1.

Events arrive as a vector of single-cycle pulses. Each counter counts the pulses of the one input its select code names. The host must move the four data bytes in order from offset 0 to offset 3. A write is held in a staging area and takes effect as a whole when offset 3 is written. A read captures the whole word when offset 0 is read, so the four bytes always belong together. Reading offset 0 of counter 0 also copies counter 1 into the shadow register in the same cycle. Software therefore reads counter 0 first and the shadow second, and gets a matched pair. Counters wrap from all ones to zero.

Top module: `pmu_byte_window`

## Requirements
- R1: After reset the index is 0x00, the control word reads 0x00000000, and counter 0 and the shadow both read 0.
- R2: A write on port 4 loads the index. A read on port 4 returns the current index.
- R3: A read result appears on `host_rdata`, with `host_rvalid` high, in the cycle after the read strobe. Data port k returns bits (31-8k) down to (24-8k) of the selected word. Port 0 returns bits 31:24 and port 3 returns bits 7:0.
- R4: Bytes written on ports 0, 1 and 2 are only staged. The selected register changes only when port 3 is written, and then takes all four bytes at once. Staged bytes that are never followed by a port 3 write leave the register unchanged.
- R5: A read of port 0 captures the whole selected word. Reads of ports 1 to 3 return bytes of that captured word, even if the live register has changed since.
- R6: The control word sits at index 0x01. Its bits 7:0 select the event for counter 0 and bits 15:8 select the event for counter 1. A code c from 0 to 25 counts pulses on `events[c]`. Any other code counts nothing. Counter 0 reads at index 0x02.
- R7: Writing the control word with bit 16 set zeroes counter 0, and with bit 17 set zeroes counter 1. The other counter is not disturbed. Both clear bits always read back as 0, and the select fields take the values written in the same word.
- R8: When a clear and a counted event fall in the same cycle, the counter ends at zero.
- R9: The shadow register sits at index 0x03. It takes the value of counter 1 in the cycle that port 0 of index 0x02 is read. At all other times it holds its value.
- R10: Writes to indices 0x00, 0x02 and 0x03 have no effect. Any index above 0x03 reads as zero.
- R11: The identification word at index 0x00 holds the implementation code in bits 31:24 (default 0x5A) and the version in bits 23:16 (default 0x03). Bits 15:8 are zero. Bits 7:0 hold the counter count (default 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Byte write strobe |
| host_rd | input | 1 | Byte read strobe |
| host_port | input | 3 | 0-3 = data byte offset, 4 = index port |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after the strobe |
| host_rvalid | output | 1 | Read data valid |
| events | input | 26 | Single-cycle event pulses |

## Verification
Two situations are hard to reach from the ports. The first is a clear landing in the very cycle an event is counted. The stimulus drives the port 3 write of the control word together with a pulse on the selected event, and then expects zero. The second is the counter moving while a word is being read. The stimulus reads offset 0, pulses the selected event before the remaining offsets are read, and expects the captured value. The same sequence shows the shadow keeping the counter 1 value from its capture while counter 1 advances further.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int REG_W    = 32;
  localparam int BYTE_W   = 8;
  localparam int IDX_W    = 8;
  localparam int PORT_W   = 3;
  localparam int SEL_W    = 8;
  localparam int NUM_CNT  = 2;
  localparam int CLR_BASE = 16;  // clear bit for counter k is CLR_BASE + k

  localparam logic [PORT_W-1:0] PORT_INDEX = 3'd4;

  typedef enum logic [IDX_W-1:0] {
    IDX_ID     = 8'h00,
    IDX_CTRL   = 8'h01,
    IDX_CNT0   = 8'h02,
    IDX_SHADOW = 8'h03
  } reg_idx_e;
endpackage

// File: rtl/pmu_host_port.sv
module pmu_host_port
  import pmu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [PORT_W-1:0]    host_port,
  input  logic [BYTE_W-1:0]    host_wdata,
  input  logic [REG_W-1:0]     live_word,
  output logic [BYTE_W-1:0]    host_rdata,
  output logic                 host_rvalid,
  output logic [IDX_W-1:0]     idx,
  output logic                 commit,
  output logic [REG_W-1:0]     commit_word,
  output logic                 snap
);
  localparam int STAGE_W = REG_W - BYTE_W;

  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [STAGE_W-1:0] stage_q, stage_d;
  logic [REG_W-1:0]   hold_q, hold_d;
  logic [BYTE_W-1:0]  rdata_q, rdata_d;
  logic               rvalid_q, rvalid_d;

  assign commit      = host_wr && (host_port == 3'd3);
  assign commit_word = {stage_q, host_wdata};
  assign snap        = host_rd && (host_port == 3'd0);
  assign idx         = idx_q;
  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;

  always_comb begin
    idx_d    = idx_q;
    stage_d  = stage_q;
    hold_d   = hold_q;
    rdata_d  = rdata_q;
    rvalid_d = 1'b0;
    if (host_wr) begin
      case (host_port)
        PORT_INDEX: idx_d = host_wdata;
        3'd0:       stage_d[23:16] = host_wdata;
        3'd1:       stage_d[15:8]  = host_wdata;
        3'd2:       stage_d[7:0]   = host_wdata;
        default:    ;
      endcase
    end
    if (host_rd) begin
      rvalid_d = 1'b1;
      case (host_port)
        3'd0: begin
          hold_d  = live_word;
          rdata_d = live_word[31:24];
        end
        3'd1:       rdata_d = hold_q[23:16];
        3'd2:       rdata_d = hold_q[15:8];
        3'd3:       rdata_d = hold_q[7:0];
        PORT_INDEX: rdata_d = idx_q;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      stage_q  <= '0;
      hold_q   <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      idx_q    <= idx_d;
      stage_q  <= stage_d;
      hold_q   <= hold_d;
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_port == PORT_INDEX) |=> idx == $past(host_wdata));

  assert_top_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_port == 3'd0) |=> (host_rvalid && host_rdata == $past(live_word[31:24])));

  assert_rvalid_only_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> !host_rvalid);
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_ctrl,
  input  logic [REG_W-1:0]               wr_word,
  output logic [NUM_CNT-1:0][SEL_W-1:0]  sel,
  output logic [NUM_CNT-1:0]             clr
);
  logic [NUM_CNT-1:0][SEL_W-1:0] sel_q, sel_d;

  assign sel = sel_q;

  always_comb begin
    sel_d = sel_q;
    clr   = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (wr_ctrl) begin
        sel_d[k] = wr_word[k*SEL_W +: SEL_W];
        clr[k]   = wr_word[CLR_BASE + k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end

  assert_sel_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ctrl |=> $stable(sel_q));
endmodule

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
  parameter int NUM_EVENTS = 26,
  parameter int SEL_W      = 8,
  parameter int CNT_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_EVENTS-1:0] events,
  input  logic [SEL_W-1:0]      sel,
  input  logic                  clr,
  output logic [CNT_W-1:0]      count
);
  logic [CNT_W-1:0] count_q, count_d;
  logic             hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_EVENTS; i++) begin
      if (sel == SEL_W'(i)) hit = hit | events[i];
    end
  end

  always_comb begin
    count_d = count_q;
    if (clr)      count_d = '0;
    else if (hit) count_d = count_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count_q == '0);

  assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)) || (count_q == '0));

  assert_bad_code_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && sel >= SEL_W'(NUM_EVENTS)) |=> $stable(count_q));
endmodule

// File: rtl/pmu_byte_window.sv
module pmu_byte_window
  import pmu_pkg::*;
#(
  parameter int          NUM_EVENTS = 26,
  parameter int          CNT_W      = 32,
  parameter logic [7:0]  IMPL_CODE  = 8'h5A,
  parameter logic [7:0]  VERS_CODE  = 8'h03
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  host_wr,
  input  logic                  host_rd,
  input  logic [PORT_W-1:0]     host_port,
  input  logic [BYTE_W-1:0]     host_wdata,
  output logic [BYTE_W-1:0]     host_rdata,
  output logic                  host_rvalid,
  input  logic [NUM_EVENTS-1:0] events
);
  localparam logic [REG_W-1:0] ID_WORD = {IMPL_CODE, VERS_CODE, 8'h00, 8'(NUM_CNT)};

  logic [IDX_W-1:0]               idx;
  logic                           commit, snap, snap_cnt0;
  logic [REG_W-1:0]               commit_word, live_word;
  logic [NUM_CNT-1:0][SEL_W-1:0]  sel;
  logic [NUM_CNT-1:0]             clr;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]               shadow_q, shadow_d;

  pmu_host_port u_host (
    .clk(clk), .rst_n(rst_n),
    .host_wr(host_wr), .host_rd(host_rd), .host_port(host_port),
    .host_wdata(host_wdata), .live_word(live_word),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .idx(idx), .commit(commit), .commit_word(commit_word), .snap(snap)
  );

  pmu_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(commit && idx == IDX_CTRL), .wr_word(commit_word),
    .sel(sel), .clr(clr)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    pmu_event_counter #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .events(events),
      .sel(sel[k]), .clr(clr[k]), .count(cnt[k])
    );
  end

  assign snap_cnt0 = snap && (idx == IDX_CNT0);

  always_comb begin
    shadow_d = shadow_q;
    if (snap_cnt0) shadow_d = cnt[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shadow_q <= '0;
    else        shadow_q <= shadow_d;
  end

  always_comb begin
    case (idx)
      IDX_ID:     live_word = ID_WORD;
      IDX_CTRL:   live_word = REG_W'(sel);
      IDX_CNT0:   live_word = REG_W'(cnt[0]);
      IDX_SHADOW: live_word = REG_W'(shadow_q);
      default:    live_word = '0;
    endcase
  end

  assert_shadow_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snap_cnt0 |=> shadow_q == $past(cnt[1]));

  assert_shadow_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_cnt0 |=> $stable(shadow_q));
endmodule

// File: tb/test_pmu_byte_window.sv
module test_pmu_byte_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr, host_rd;
  logic [2:0]  host_port;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic [25:0] events;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  always #5 clk = ~clk;

  pmu_byte_window i_pmu_byte_window (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_port(host_port), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .events(events)
  );

  // monitor: compares every returned byte with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data: actual %02h expected none", host_rdata);
      end else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string      r = req_q.pop_front();
        if (host_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %02h expected %02h", r, host_rdata, e);
        end
      end
    end
  end

  task automatic op(input bit wr, input bit rd, input logic [2:0] port,
                    input logic [7:0] d, input logic [25:0] ev);
    @(negedge clk);
    host_wr = wr; host_rd = rd; host_port = port; host_wdata = d; events = ev;
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; events = '0;
  endtask

  task automatic set_index(input logic [7:0] i);
    op(1'b1, 1'b0, 3'd4, i, '0);
  endtask

  task automatic write_word(input logic [31:0] w);
    for (int k = 0; k < 4; k++) op(1'b1, 1'b0, 3'(k), w[31-8*k -: 8], '0);
  endtask

  task automatic expect_word(input logic [7:0] i, input logic [31:0] w, input string r);
    set_index(i);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(w[31-8*k -: 8]);
      req_q.push_back(r);
    end
    for (int k = 0; k < 4; k++) op(1'b0, 1'b1, 3'(k), 8'h00, '0);
  endtask

  task automatic expect_index(input logic [7:0] i, input string r);
    exp_q.push_back(i);
    req_q.push_back(r);
    op(1'b0, 1'b1, 3'd4, 8'h00, '0);
  endtask

  task automatic pulse(input logic [25:0] ev, input int n);
    for (int k = 0; k < n; k++) op(1'b0, 1'b0, 3'd0, 8'h00, ev);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements): actual hung expected finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_port = '0;
    host_wdata = '0; events = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 index readback
    expect_index(8'h00, "R1 reset index / R2");
    expect_word(8'h00, 32'h5A03_0002, "R11 id fields / R3 byte order");
    expect_word(8'h01, 32'h0000_0000, "R1 reset control");
    expect_word(8'h02, 32'h0000_0000, "R1 reset counter0");
    expect_word(8'h03, 32'h0000_0000, "R1 reset shadow");

    // R6 select fields, R4 staged write
    set_index(8'h01);
    write_word(32'h0000_0703);
    expect_word(8'h01, 32'h0000_0703, "R6 select readback / R4 commit");
    for (int k = 0; k < 3; k++) op(1'b1, 1'b0, 3'(k), 8'hAA + 8'(k), '0);
    expect_word(8'h01, 32'h0000_0703, "R4 partial write ignored");

    // R6 counting: counter0 on event 3, counter1 on event 7
    pulse(26'd1 << 3, 5);
    pulse(26'd1 << 7, 2);
    pulse(26'd1 << 10, 3);
    pulse((26'd1 << 3) | (26'd1 << 7), 1);
    expect_word(8'h02, 32'd6, "R6 counter0 count");
    expect_word(8'h03, 32'd3, "R9 shadow after counter0 read");

    // R5 snapshot while counter moves; R9 shadow holds
    set_index(8'h02);
    for (int k = 0; k < 4; k++) begin
      exp_q.push_back(k == 3 ? 8'd6 : 8'd0);
      req_q.push_back("R5 snapshot consistency");
    end
    op(1'b0, 1'b1, 3'd0, 8'h00, '0);
    pulse(26'd1 << 3, 1);
    for (int k = 1; k < 4; k++) op(1'b0, 1'b1, 3'(k), 8'h00, '0);
    pulse(26'd1 << 7, 2);
    expect_word(8'h03, 32'd3, "R9 shadow holds");
    expect_word(8'h02, 32'd7, "R5 live counter after snapshot");
    expect_word(8'h03, 32'd5, "R9 shadow recaptured");

    // R7 clear counter0 only, clear bits read 0
    set_index(8'h01);
    write_word(32'h0001_0703);
    expect_word(8'h01, 32'h0000_0703, "R7 clear bits read 0");
    expect_word(8'h02, 32'd0, "R7 counter0 cleared");
    expect_word(8'h03, 32'd5, "R7 counter1 untouched");

    // R8 clear and event in the same cycle
    pulse(26'd1 << 3, 2);
    set_index(8'h01);
    for (int k = 0; k < 3; k++) op(1'b1, 1'b0, 3'(k), (k == 1) ? 8'h01 : (k == 2 ? 8'h07 : 8'h00), '0);
    op(1'b1, 1'b0, 3'd3, 8'h03, 26'd1 << 3);
    expect_word(8'h02, 32'd0, "R8 clear wins over event");

    // R7 clear counter1
    set_index(8'h01);
    write_word(32'h0002_0703);
    expect_word(8'h02, 32'd0, "R7 counter0 read");
    expect_word(8'h03, 32'd0, "R7 counter1 cleared");

    // R6 out-of-range codes count nothing
    set_index(8'h01);
    write_word(32'h0003_FF1A);
    expect_word(8'h01, 32'h0000_FF1A, "R6 select readback");
    pulse(26'h3FF_FFFF, 4);
    expect_word(8'h02, 32'd0, "R6 code 26 counts nothing");
    expect_word(8'h03, 32'd0, "R6 code 255 counts nothing");

    // R6 highest valid code 25
    set_index(8'h01);
    write_word(32'h0000_FF19);
    pulse(26'd1 << 25, 3);
    expect_word(8'h02, 32'd3, "R6 code 25 counts");

    // R10 writes to read-only indices ignored, unused index reads 0
    set_index(8'h00);
    write_word(32'hFFFF_FFFF);
    expect_word(8'h00, 32'h5A03_0002, "R10 id write ignored");
    set_index(8'h02);
    write_word(32'h1234_5678);
    expect_word(8'h02, 32'd3, "R10 counter0 write ignored");
    set_index(8'h03);
    write_word(32'h1122_3344);
    expect_word(8'h03, 32'd0, "R10 shadow write ignored");
    set_index(8'h09);
    expect_index(8'h09, "R2 index readback");
    expect_word(8'h09, 32'd0, "R10 unused index reads zero");

    repeat (4) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R3 missing read data: actual %0d pending expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule